// File: doc/BRIEF.md
# VPW Symbol Transmitter with Echo-Timed Symbol Ends

This block drives the transmit pin of a variable-pulse-width bus node toward an external transceiver. It sends a start-of-frame symbol and then a stream of data symbols whose widths encode bits. The block does not end a symbol by counting from its own pin edge. It watches the bus level that the transceiver echoes back, passes that level through a glitch filter, and starts a symbol timer on the filtered edge. When the timer runs out, the block flips or releases the pin. The timer load is the nominal symbol width minus the programmed transceiver delay minus the filter latency. The pin width therefore comes out nominal when the programmed delay matches the real one.

Because the timer always starts on the observed bus edge, the block locks onto whichever node moved the bus first. If another transmitter goes active a few cycles early, this block ends its start symbol 200 cycles after that earlier edge. If this block goes first, its own edge sets the timing. Each clock cycle stands for one microsecond of bus time. Data bits are handed in one at a time through a single holding register, which is refilled while the current symbol is still in flight.

Top module: `vpw_sym_tx`

## Requirements
- R1: After reset, `vpw_out`, `done` and `busy` are 0 and `bit_ready` is 1.
- R2: The filtered bus level follows `vpw_in` only after the input has differed from it on 8 consecutive clock edges. A pulse of 7 cycles or less is ignored, so it does not block a following start.
- R3: While the block is idle and the filtered bus is passive (0), `start` sampled high drives `vpw_out` to 1 on that same edge. While the filtered bus is active, `start` is ignored.
- R4: With a 14-cycle echo delay and `dly_cfg` = 14, the start symbol holds `vpw_out` at 1 for exactly 200 cycles.
- R5: The symbol timer starts at the filtered echo edge and counts nominal − `dly_cfg` − 8 cycles. With a 14-cycle echo delay, `dly_cfg` = 10 gives a 204-cycle start symbol and `dly_cfg` = 20 gives 194.
- R6: If another node drives the bus d cycles before this block's edge reaches the transceiver, `vpw_out` falls 200 cycles after that earlier edge, so the pin pulse lasts 200 − d cycles.
- R7: If another node drives the bus after this block does, the start symbol still lasts exactly 200 cycles at the pin.
- R8: Data symbols alternate in level, starting with passive (0) after the start symbol. A bit of 1 is 64 cycles passive or 128 cycles active. A bit of 0 is 128 cycles passive or 64 cycles active. `vpw_out` stays constant within a symbol.
- R9: `bit_ready` is 1 while the holding register is empty. `bit_load` stores `bit_val` and clears `bit_ready`. A `bit_load` while `bit_ready` is 0 is ignored.
- R10: `done` pulses for one cycle at each symbol end, in the cycle the pin takes its new level. If no bit is held at that point, `vpw_out` becomes 0 and `busy` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, one cycle per microsecond |
| rst_n | input | 1 | Active-low synchronous reset |
| dly_cfg | input | 5 | Expected transceiver delay in cycles |
| start | input | 1 | Request to send a start-of-frame symbol |
| bit_load | input | 1 | Write `bit_val` into the holding register |
| bit_val | input | 1 | Next data bit |
| bit_ready | output | 1 | Holding register is empty |
| vpw_in | input | 1 | Echoed bus level from the transceiver |
| vpw_out | output | 1 | Transmit level toward the transceiver |
| busy | output | 1 | A symbol is in progress |
| done | output | 1 | One-cycle pulse at each symbol end |

## Verification
The first result of a start request, `vpw_out` going high, is visible in the cycle right after the edge that samples `start`. Every symbol end is due 22 cycles of echo and filter delay plus the timer load after the pin edge that began the symbol. `done` and the new pin level appear in the same cycle.

The bench samples everything on the falling clock edge. It measures each symbol as a run of equal `vpw_out` samples, so every expected width is compared in whole cycles with no offset. Tests that check a filtered bus state wait on the raw echo, then count the filter window before applying `start`.

// File: rtl/vpw_sym_tx.sv
module vpw_sym_tx #(
  parameter int FILT_LEN = 8,
  parameter int SOF_US   = 200,
  parameter int SHORT_US = 64,
  parameter int LONG_US  = 128,
  parameter int DLY_W    = 5,
  parameter int TMR_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DLY_W-1:0] dly_cfg,
  input  logic             start,
  input  logic             bit_load,
  input  logic             bit_val,
  output logic             bit_ready,
  input  logic             vpw_in,
  output logic             vpw_out,
  output logic             busy,
  output logic             done
);
  localparam int FC_W = $clog2(FILT_LEN + 1);

  typedef enum logic [1:0] {K_SOF, K_SHORT, K_LONG} kind_t;

  logic [FC_W-1:0]  fcnt;
  logic             filt_q;
  logic             busy_q, armed_q, out_q, done_q;
  logic             nxt_vld, nxt_bit;
  kind_t            kind;
  logic [TMR_W-1:0] tmr, nom, tmr_load;

  wire filt_flip = (vpw_in != filt_q) && (fcnt == FC_W'(FILT_LEN - 1));
  wire sym_end   = busy_q && armed_q && (tmr == TMR_W'(1));
  wire new_lvl   = ~out_q;
  wire nxt_short = nxt_bit ^ new_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcnt   <= '0;
      filt_q <= 1'b0;
    end else if (vpw_in == filt_q) begin
      fcnt <= '0;
    end else if (filt_flip) begin
      filt_q <= vpw_in;
      fcnt   <= '0;
    end else begin
      fcnt <= fcnt + FC_W'(1);
    end
  end

  always_comb begin
    case (kind)
      K_SOF:   nom = TMR_W'(SOF_US);
      K_SHORT: nom = TMR_W'(SHORT_US);
      default: nom = TMR_W'(LONG_US);
    endcase
    tmr_load = nom - TMR_W'(dly_cfg) - TMR_W'(FILT_LEN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      armed_q <= 1'b0;
      out_q   <= 1'b0;
      done_q  <= 1'b0;
      kind    <= K_SOF;
      tmr     <= '0;
    end else begin
      done_q <= sym_end;
      if (!busy_q) begin
        if (start && !filt_q) begin
          out_q   <= 1'b1;
          busy_q  <= 1'b1;
          armed_q <= 1'b0;
          kind    <= K_SOF;
        end
      end else if (!armed_q) begin
        if (filt_flip && (vpw_in == out_q)) begin
          armed_q <= 1'b1;
          tmr     <= tmr_load;
        end
      end else if (sym_end) begin
        armed_q <= 1'b0;
        busy_q  <= nxt_vld;
        out_q   <= nxt_vld ? new_lvl : 1'b0;
        kind    <= nxt_short ? K_SHORT : K_LONG;
      end else begin
        tmr <= tmr - TMR_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt_vld <= 1'b0;
      nxt_bit <= 1'b0;
    end else if (sym_end && nxt_vld) begin
      nxt_vld <= 1'b0;
    end else if (bit_load && !nxt_vld) begin
      nxt_vld <= 1'b1;
      nxt_bit <= bit_val;
    end
  end

  assign vpw_out   = out_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign bit_ready = ~nxt_vld;
endmodule

// File: rtl/vpw_sym_tx_chk.sv
module vpw_sym_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic filt,
  input logic vpw_in,
  input logic vpw_out,
  input logic done,
  input logic bit_ready
);
  p_filt_settled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt) |-> ((vpw_in == filt) && ($past(vpw_in) == filt)));

  p_start_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !filt) |=> (vpw_out && busy));

  p_hold_in_symbol_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !done) |-> $stable(vpw_out));

  p_ready_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_ready |=> (!bit_ready || done));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && busy) |-> (vpw_out != $past(vpw_out)));
endmodule

bind vpw_sym_tx vpw_sym_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .filt(filt_q),
  .vpw_in(vpw_in), .vpw_out(vpw_out), .done(done), .bit_ready(bit_ready)
);

// File: tb/test_vpw_sym_tx.sv
`timescale 1ns/1ps
module test_vpw_sym_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] dly_cfg = 5'd14;
  logic       start = 1'b0, bit_load = 1'b0, bit_val = 1'b0;
  logic       tx2 = 1'b0;
  logic       bit_ready, vpw_in, vpw_out, busy, done;
  logic [13:0] line = '0;
  int checks = 0, errors = 0;
  int done_cnt = 0;
  logic last_out = 1'b0;
  bit finished = 1'b0;
  int runs[8];

  always #5 clk = ~clk;

  always_ff @(posedge clk) line <= {line[12:0], vpw_out | tx2};
  assign vpw_in = line[13];

  vpw_sym_tx i_vpw_sym_tx (
    .clk(clk), .rst_n(rst_n), .dly_cfg(dly_cfg), .start(start),
    .bit_load(bit_load), .bit_val(bit_val), .bit_ready(bit_ready),
    .vpw_in(vpw_in), .vpw_out(vpw_out), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R10: done must coincide with a pin change while the frame continues
  always @(negedge clk) begin
    if (rst_n && done) begin
      done_cnt++;
      if (busy) chk("R10 done with pin edge", int'(vpw_out != last_out), 1);
    end
    last_out = vpw_out;
  end

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic measure(input int n);
    for (int s = 0; s < n; s++) begin
      automatic logic lvl = vpw_out;
      automatic int cnt = 0;
      while (vpw_out == lvl) begin
        cnt++;
        @(negedge clk);
      end
      runs[s] = cnt;
    end
  endtask

  task automatic feed(input logic b);
    while (!bit_ready) @(negedge clk);
    bit_load = 1'b1;
    bit_val  = b;
    @(negedge clk);
    bit_load = 1'b0;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 vpw_out", int'(vpw_out), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 bit_ready", int'(bit_ready), 1);
  endtask

  task automatic t_sof(input logic [4:0] dly, input int exp, input string req);
    dly_cfg = dly;
    done_cnt = 0;
    pulse_start();
    chk("R3 rise after start", int'(vpw_out), 1);
    measure(1);
    chk(req, runs[0], exp);
    chk("R10 released, idle", int'(busy), 0);
    settle();
    chk("R10 one done per symbol", done_cnt, 1);
    dly_cfg = 5'd14;
  endtask

  task automatic t_other_early(input int lead);
    tx2 = 1'b1;
    repeat (lead - 1) @(negedge clk);
    pulse_start();
    measure(1);
    tx2 = 1'b0;
    chk("R6 early transmitter", runs[0], 200 - lead);
    settle();
  endtask

  task automatic t_other_late();
    pulse_start();
    repeat (5) @(negedge clk);
    tx2 = 1'b1;
    measure(1);
    tx2 = 1'b0;
    chk("R7 late transmitter", runs[0] + 5, 200);
    settle();
  endtask

  task automatic t_glitch();
    tx2 = 1'b1;
    repeat (7) @(negedge clk);
    tx2 = 1'b0;
    while (!vpw_in) @(negedge clk);
    while (vpw_in) @(negedge clk);
    pulse_start();
    chk("R2 short glitch filtered", int'(vpw_out), 1);
    measure(1);
    chk("R2 SOF after glitch", runs[0], 200);
    settle();
  endtask

  task automatic t_busy_bus();
    tx2 = 1'b1;
    while (!vpw_in) @(negedge clk);
    repeat (10) @(negedge clk);
    pulse_start();
    repeat (3) @(negedge clk);
    chk("R3 start ignored on active bus", int'(vpw_out), 0);
    tx2 = 1'b0;
    settle();
    chk("R3 stays idle", int'(busy), 0);
  endtask

  task automatic t_data();
    done_cnt = 0;
    pulse_start();
    fork
      measure(5);
      begin
        feed(1'b1);
        feed(1'b0);
        feed(1'b0);
        feed(1'b1);
      end
    join
    chk("R4 SOF in frame", runs[0], 200);
    chk("R8 bit1 passive short", runs[1], 64);
    chk("R8 bit0 active short", runs[2], 64);
    chk("R8 bit0 passive long", runs[3], 128);
    chk("R8 bit1 active long", runs[4], 128);
    settle();
    chk("R10 idle after last symbol", int'(busy), 0);
    chk("R10 done count", done_cnt, 5);
  endtask

  task automatic t_hold_reg();
    pulse_start();
    feed(1'b1);
    chk("R9 ready cleared", int'(bit_ready), 0);
    bit_load = 1'b1;
    bit_val  = 1'b0;
    @(negedge clk);
    bit_load = 1'b0;
    fork
      measure(3);
      feed(1'b1);
    join
    chk("R9 ignored load kept bit", runs[1], 64);
    chk("R9 third bit active long", runs[2], 128);
    settle();
    chk("R9 ready after drain", int'(bit_ready), 1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sof(5'd14, 200, "R4 SOF width");
    t_sof(5'd10, 204, "R5 delay 10");
    t_sof(5'd20, 194, "R5 delay 20");
    t_other_early(5);
    t_other_late();
    t_glitch();
    t_busy_bus();
    t_data();
    t_hold_reg();
    summary();
  end
endmodule